// File: doc/BRIEF.md
# Four-Bit Binary to Two-Digit Decimal Display Converter

This block takes an unsigned 4-bit binary value and splits it into a tens digit and a units digit. It then drives two seven-segment displays. It is purely combinational and has no clock or reset. Every output follows the input within the same cycle.

The block is built from four parts:

- A comparator raises a flag when the value exceeds nine.
- A correction stage maps the values ten to fifteen onto zero to five.
- A bank of per-bit 2:1 multiplexers, steered by the flag, selects either the raw input or the corrected value as the units digit.
- Two segment drivers show the digits. The tens driver takes only the flag and shows a 0 or a 1. The units driver decodes the units digit.

All logic is written as continuous Boolean equations. The block has no stream traffic and no back-pressure, so every pin is a plain level signal.

Top module: `bin2dec_disp`

## Requirements
- R1: `over9_o` is 1 exactly when `bin_i` is greater than 9.
- R2: When `bin_i` is 0 to 9, `units_o` equals `bin_i`, and the corrected value has no effect on `units_o`.
- R3: When `bin_i` is 10 to 15, `units_o` equals `bin_i` minus 10, running 0 to 5 in order.
- R4: The segment vectors are active-low with bit 6 down to bit 0 being g,f,e,d,c,b,a. `seg_tens_n` is 7'h40 (digit 0) when `over9_o` is 0 and 7'h79 (digit 1) when it is 1.
- R5: For units digits 0 to 9, `seg_units_n` is 40,79,24,30,19,12,02,78,00,10 (hex) respectively.
- R6: For every input, 10 times the tens digit plus `units_o` equals `bin_i`, and `units_o` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bin_i | input | 4 | Unsigned binary value to convert |
| units_o | output | 4 | Units decimal digit, coded in binary |
| over9_o | output | 1 | High when the input exceeds nine, which is also the tens digit |
| seg_units_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} for the units digit |
| seg_tens_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} for the tens digit |

## Verification
The comparator flag and the correction path act in the same evaluation: whenever the input is 10 or more, the flag switches the tens display and also selects the corrected units value. The bench provokes this by stepping the input across the 9-to-10 and 15-to-0 edges and sweeping the upper range. In each case it judges the tens pattern, the units digit and the units pattern together against values computed from the input. It also checks that the reconstructed decimal value matches the input.

// File: rtl/bin2dec_pkg.sv
package bin2dec_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned RADIX   = 10;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;
  typedef enum logic [0:0] {SEG_FULL = 1'b0, SEG_ZERO_ONE = 1'b1} seg_mode_e;
endpackage

// File: rtl/bin2dec_cmp.sv
module bin2dec_cmp
  import bin2dec_pkg::*;
(
  input  digit_t val_i,
  output logic   gt9_o
);
  // above nine: bit3 set together with bit2 or bit1
  assign gt9_o = val_i[3] & (val_i[2] | val_i[1]);
endmodule

// File: rtl/bin2dec_fix.sv
module bin2dec_fix
  import bin2dec_pkg::*;
(
  input  digit_t val_i,
  output digit_t fix_o
);
  // subtract-ten mapping, meaningful only for inputs 10..15
  assign fix_o[3] = 1'b0;
  assign fix_o[2] = val_i[2] & val_i[1];
  assign fix_o[1] = ~val_i[1];
  assign fix_o[0] = val_i[0];
endmodule

// File: rtl/bin2dec_mux.sv
module bin2dec_mux
  import bin2dec_pkg::*;
#(
  parameter int unsigned W = DIGIT_W
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] alt_i,
  input  logic         sel_i,
  output logic [W-1:0] out_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign out_o[k] = (~sel_i & raw_i[k]) | (sel_i & alt_i[k]);
  end
endmodule

// File: rtl/bin2dec_seg.sv
module bin2dec_seg
  import bin2dec_pkg::*;
#(
  parameter seg_mode_e MODE       = SEG_FULL,
  parameter bit        ACTIVE_LOW = 1'b1
) (
  input  digit_t val_i,
  output seg_t   seg_o
);
  seg_t hi;  // active-high {g,f,e,d,c,b,a}
  logic x3, x2, x1, x0;
  assign {x3, x2, x1, x0} = val_i;

  if (MODE == SEG_FULL) begin : g_full
    assign hi[0] = x3 | x1 | (x2 & x0) | (~x2 & ~x0);
    assign hi[1] = ~x2 | (x1 & x0) | (~x1 & ~x0);
    assign hi[2] = x2 | ~x1 | x0;
    assign hi[3] = x3 | (~x2 & ~x0) | (~x2 & x1) | (x1 & ~x0) | (x2 & ~x1 & x0);
    assign hi[4] = (~x2 & ~x0) | (x1 & ~x0);
    assign hi[5] = x3 | (~x1 & ~x0) | (x2 & ~x1) | (x2 & ~x0);
    assign hi[6] = x3 | (~x2 & x1) | (x1 & ~x0) | (x2 & ~x1);
  end else begin : g_zero_one
    // only bit0 matters: shows 0 or 1
    assign hi[0] = ~x0;
    assign hi[1] = 1'b1;
    assign hi[2] = 1'b1;
    assign hi[3] = ~x0;
    assign hi[4] = ~x0;
    assign hi[5] = ~x0;
    assign hi[6] = 1'b0;
  end

  if (ACTIVE_LOW) begin : g_low
    assign seg_o = ~hi;
  end else begin : g_high
    assign seg_o = hi;
  end
endmodule

// File: rtl/bin2dec_disp.sv
module bin2dec_disp
  import bin2dec_pkg::*;
(
  input  logic [3:0] bin_i,
  output logic [3:0] units_o,
  output logic       over9_o,
  output logic [6:0] seg_units_n,
  output logic [6:0] seg_tens_n
);
  logic   gt9;
  digit_t fixed;
  digit_t units;
  digit_t tens_val;

  bin2dec_cmp u_cmp (.val_i(bin_i), .gt9_o(gt9));
  bin2dec_fix u_fix (.val_i(bin_i), .fix_o(fixed));

  bin2dec_mux #(.W(DIGIT_W)) u_mux (
    .raw_i(bin_i), .alt_i(fixed), .sel_i(gt9), .out_o(units)
  );

  assign tens_val = {{(DIGIT_W-1){1'b0}}, gt9};

  bin2dec_seg #(.MODE(SEG_FULL), .ACTIVE_LOW(1'b1)) u_seg_u (
    .val_i(units), .seg_o(seg_units_n)
  );
  bin2dec_seg #(.MODE(SEG_ZERO_ONE), .ACTIVE_LOW(1'b1)) u_seg_t (
    .val_i(tens_val), .seg_o(seg_tens_n)
  );

  assign units_o = units;
  assign over9_o = gt9;
endmodule

// File: rtl/bin2dec_disp_chk.sv
module bin2dec_disp_chk (
  input logic [3:0] bin_i,
  input logic [3:0] units_o,
  input logic       over9_o,
  input logic [6:0] seg_tens_n
);
  always_comb begin
    AST_FLAG_ABOVE_NINE: assert (over9_o == (bin_i > 4'd9)); // R1
    AST_LOW_PASS: assert (over9_o || (units_o == bin_i)); // R2
    AST_HIGH_FOLD: assert (!over9_o || (units_o == bin_i - 4'd10)); // R3
    AST_TENS_PATTERN: assert (seg_tens_n == (over9_o ? 7'h79 : 7'h40)); // R4
    AST_SUM_MATCH: assert ((units_o <= 4'd9) && ({1'b0, units_o} + (over9_o ? 5'd10 : 5'd0) == {1'b0, bin_i})); // R6
  end
endmodule

bind bin2dec_disp bin2dec_disp_chk u_chk (
  .bin_i(bin_i), .units_o(units_o), .over9_o(over9_o), .seg_tens_n(seg_tens_n)
);

// File: tb/bin2dec_disp_tb_top.sv
`timescale 1ns/1ps
module bin2dec_disp_tb_top;
  logic       clk = 1'b0;
  logic [3:0] bin_i = 4'd0;
  logic [3:0] units_o;
  logic       over9_o;
  logic [6:0] seg_units_n, seg_tens_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bin2dec_disp dut_i (
    .bin_i(bin_i), .units_o(units_o), .over9_o(over9_o),
    .seg_units_n(seg_units_n), .seg_tens_n(seg_tens_n)
  );

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; default: return 7'h10;
    endcase
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s bin=%0d actual=%0h expected=%0h", req, bin_i, act, exp);
    end
  endtask

  task automatic apply(input int v);
    @(negedge clk);
    bin_i = 4'(v);
    #1;
  endtask

  task automatic t_reset_state;
    apply(0);
    cmp("R1", over9_o, 0);
    cmp("R2", units_o, 0);
    cmp("R4", seg_tens_n, 7'h40);
    cmp("R5", seg_units_n, 7'h40);
  endtask

  task automatic t_low_range;
    for (int v = 0; v <= 9; v++) begin
      apply(v);
      cmp("R1", over9_o, 0);
      cmp("R2", units_o, v);
      cmp("R5", seg_units_n, exp_seg(v));
      cmp("R4", seg_tens_n, 7'h40);
    end
  endtask

  task automatic t_high_range;
    for (int v = 10; v <= 15; v++) begin
      apply(v);
      cmp("R1", over9_o, 1);
      cmp("R3", units_o, v - 10);
      cmp("R4", seg_tens_n, 7'h79);
      cmp("R5", seg_units_n, exp_seg(v - 10));
    end
  endtask

  task automatic t_edges;
    int seq[6] = '{9, 10, 9, 15, 0, 10};
    foreach (seq[i]) begin
      apply(seq[i]);
      cmp("R1", over9_o, seq[i] > 9 ? 1 : 0);
      cmp("R4", seg_tens_n, seq[i] > 9 ? 7'h79 : 7'h40);
      cmp(seq[i] > 9 ? "R3" : "R2", units_o, seq[i] % 10);
    end
  endtask

  task automatic t_sum;
    for (int v = 15; v >= 0; v--) begin
      apply(v);
      cmp("R6", 10 * over9_o + units_o, v);
      cmp("R6", units_o <= 9 ? 1 : 0, 1);
    end
  endtask

  initial begin
    t_reset_state();
    t_low_range();
    t_high_range();
    t_edges();
    t_sum();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule